// File: doc/BRIEF.md
# ECC Error Logger with System Error Output

This block sits behind a memory ECC checker. The checker reports each failing access as a one-cycle pulse on one of two inputs: one for a single-bit error that was corrected, one for a multi-bit error that could not be corrected. Each pulse comes with the 3-bit number of the DRAM row that was accessed. The logger keeps a flag for each error class, together with the row of the first error of that class. Software reads all of this from one status word and clears the flags by writing ones to them.

A command word sets three things. It selects which error classes drive the active-low system error output. It can request a bad-parity indication for every uncorrectable error. It chooses between two behaviours for the system error output: a one-clock strobe at the moment a flag sets, or a level that stays active until software has cleared every enabled flag. The ECC syndrome logic and the bus parity generator are outside this block.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, the status word is 0, `serr_n` is 1 and `bad_par` is 0.
- R2: A pulse on `ce_evt` sets status bit 0 and loads `ce_row` into status bits 3:1 if bit 0 was clear. Both changes are visible in the cycle after the pulse.
- R3: A pulse on `ue_evt` sets status bit 4 and loads `ue_row` into status bits 7:5 if bit 4 was clear. Both changes are visible in the cycle after the pulse.
- R4: While a flag stays set, further events of the same class leave its row field unchanged.
- R5: A status write with `st_wdata` bit 0 (or bit 4) at 1 clears that flag in the next cycle. Data bits at 0, and all other bit positions, have no effect.
- R6: An event and a clearing write to the same flag in one cycle leave the flag set, and its row field takes the row of the new event.
- R7: Correctable and uncorrectable events in the same cycle set both flags and capture both rows.
- R8: `cfg` bit 0 allows correctable errors to drive `serr_n`, and `cfg` bit 1 allows uncorrectable errors to drive it. A class whose enable bit is 0 never drives `serr_n` low.
- R9: With `cfg` bit 7 at 0, `serr_n` goes low for exactly one cycle: the cycle after an enabled flag goes from 0 to 1. An event that finds its flag already set produces no strobe.
- R10: With `cfg` bit 7 at 1, `serr_n` is low whenever an enabled flag is set. It returns high in the cycle after the write that clears the last enabled flag.
- R11: With `cfg` bit 2 at 1, every `ue_evt` pulse drives `bad_par` high for the following cycle only. `bad_par` stays 0 when `cfg` bit 2 is 0 and for correctable events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable (single-bit) error pulse |
| ce_row | input | 3 | DRAM row of the correctable error |
| ue_evt | input | 1 | Uncorrectable (multi-bit) error pulse |
| ue_row | input | 3 | DRAM row of the uncorrectable error |
| cfg | input | 8 | Command word: bit0/bit1 SERR enables, bit2 bad parity, bit7 level mode |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Status write data; ones at bit 0 and bit 4 clear the flags |
| status | output | 8 | Status: {ue row, ue flag, ce row, ce flag} |
| serr_n | output | 1 | Active-low system error |
| bad_par | output | 1 | Request to force bad parity |

## Verification
If a flag or a row register holds a wrong value, the status word shows it in the cycle after the event or write. The row field reveals a lost hold or a missed re-capture when the next event of the same class arrives. If the SERR edge detector holds a wrong value, the error shows on `serr_n` within one cycle. In pulse mode it appears as a missing, doubled or stretched strobe. In level mode it appears as a release that comes early or late relative to the clearing write. A fault in the parity path appears one cycle after the uncorrectable event.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
  localparam int CFG_W       = 8;
  localparam int CFG_CE_SERR = 0;
  localparam int CFG_UE_SERR = 1;
  localparam int CFG_BADPAR  = 2;
  localparam int CFG_HOLD    = 7;
  localparam int N_CLASS     = 2;

  typedef enum logic { CLS_CE = 1'b0, CLS_UE = 1'b1 } err_class_e;

  // width of one {row, flag} record in the status word
  function automatic int rec_width(input int row_w);
    return row_w + 1;
  endfunction

  // bit position of a class flag in the status word
  function automatic int flag_pos(input int row_w, input int cls);
    return cls * rec_width(row_w);
  endfunction

  // level request: any enabled class with its flag set
  function automatic logic serr_level(input logic [N_CLASS-1:0] flags,
                                      input logic [N_CLASS-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/ecc_log_rec.sv
`timescale 1ns/1ps
module ecc_log_rec #(
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [ROW_W-1:0] row_in,
  input  logic             clr,
  output logic             flag_q,
  output logic [ROW_W-1:0] row_q,
  output logic             rise
);
  logic take_row;

  // a new 0-to-1 transition of the flag
  assign rise     = evt & ~flag_q;
  // capture when the flag is clear, or is being cleared this cycle
  assign take_row = evt & (~flag_q | clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      row_q  <= '0;
    end else begin
      if (evt)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (take_row) row_q  <= row_in;
    end
  end
endmodule

// File: rtl/ecc_log_serr.sv
`timescale 1ns/1ps
module ecc_log_serr
  import ecc_log_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] rise,
  input  logic [N_CLASS-1:0] flags,
  input  logic [N_CLASS-1:0] en,
  input  logic               hold_mode,
  output logic               serr_n
);
  logic trig;
  logic pulse_q;
  logic lvl;

  assign trig = |(rise & en);
  assign lvl  = serr_level(flags, en);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= trig;
  end

  assign serr_n = hold_mode ? ~lvl : ~pulse_q;
endmodule

// File: rtl/ecc_log_par.sv
`timescale 1ns/1ps
module ecc_log_par (
  input  logic clk,
  input  logic rst_n,
  input  logic ue_evt,
  input  logic force_en,
  output logic bad_par
);
  always_ff @(posedge clk) begin
    if (!rst_n) bad_par <= 1'b0;
    else        bad_par <= ue_evt & force_en;
  end
endmodule

// File: rtl/ecc_err_logger.sv
`timescale 1ns/1ps
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ROW_W = 3,
  localparam int REC_W  = ROW_W + 1,
  localparam int STAT_W = N_CLASS * REC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic [ROW_W-1:0]  ce_row,
  input  logic              ue_evt,
  input  logic [ROW_W-1:0]  ue_row,
  input  logic [CFG_W-1:0]  cfg,
  input  logic              st_wr,
  input  logic [STAT_W-1:0] st_wdata,
  output logic [STAT_W-1:0] status,
  output logic              serr_n,
  output logic              bad_par
);
  logic [N_CLASS-1:0] evt_w;
  logic [N_CLASS-1:0] clr_w;
  logic [N_CLASS-1:0] flag_w;
  logic [N_CLASS-1:0] rise_w;
  logic [N_CLASS-1:0] en_w;
  logic [ROW_W-1:0]   row_in_w [N_CLASS];
  logic [ROW_W-1:0]   row_q_w  [N_CLASS];

  assign evt_w[CLS_CE]    = ce_evt;
  assign evt_w[CLS_UE]    = ue_evt;
  assign row_in_w[CLS_CE] = ce_row;
  assign row_in_w[CLS_UE] = ue_row;
  assign en_w[CLS_CE]     = cfg[CFG_CE_SERR];
  assign en_w[CLS_UE]     = cfg[CFG_UE_SERR];

  for (genvar k = 0; k < N_CLASS; k++) begin : g_rec
    assign clr_w[k] = st_wr & st_wdata[flag_pos(ROW_W, k)];

    ecc_log_rec #(.ROW_W(ROW_W)) u_rec (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_w[k]),
      .row_in (row_in_w[k]),
      .clr    (clr_w[k]),
      .flag_q (flag_w[k]),
      .row_q  (row_q_w[k]),
      .rise   (rise_w[k])
    );

    assign status[k*REC_W]            = flag_w[k];
    assign status[k*REC_W+1 +: ROW_W] = row_q_w[k];
  end

  ecc_log_serr u_serr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise_w),
    .flags     (flag_w),
    .en        (en_w),
    .hold_mode (cfg[CFG_HOLD]),
    .serr_n    (serr_n)
  );

  ecc_log_par u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .ue_evt   (ue_evt),
    .force_en (cfg[CFG_BADPAR]),
    .bad_par  (bad_par)
  );
endmodule

// File: rtl/ecc_err_logger_chk.sv
`timescale 1ns/1ps
module ecc_err_logger_chk
  import ecc_log_pkg::*;
#(
  parameter int ROW_W = 3,
  localparam int REC_W  = ROW_W + 1,
  localparam int STAT_W = N_CLASS * REC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_evt,
  input logic              ue_evt,
  input logic [CFG_W-1:0]  cfg,
  input logic              st_wr,
  input logic [STAT_W-1:0] st_wdata,
  input logic [STAT_W-1:0] status,
  input logic              serr_n,
  input logic              bad_par,
  input logic [N_CLASS-1:0] rise_w
);
  localparam int CE_F = 0;
  localparam int UE_F = REC_W;

  a_r2_ce_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> status[CE_F]);

  a_r3_ue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> status[UE_F]);

  a_r4_ce_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status[CE_F] && !(st_wr && st_wdata[CE_F])) |=> $stable(status[ROW_W:1]));

  a_r4_ue_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status[UE_F] && !(st_wr && st_wdata[UE_F])) |=> $stable(status[STAT_W-1:UE_F+1]));

  a_r5_ce_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_wdata[CE_F] && !ce_evt) |=> !status[CE_F]);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!serr_n && !cfg[CFG_HOLD]) |=> (serr_n || cfg[CFG_HOLD]));

  a_r9_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[CFG_HOLD] && $past(!cfg[CFG_HOLD]) && $fell(serr_n)) |-> $past(|rise_w));

  a_r10_level_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[CFG_HOLD] && !(status[CE_F] && cfg[CFG_CE_SERR])
                   && !(status[UE_F] && cfg[CFG_UE_SERR])) |-> serr_n);

  a_r11_badpar_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && cfg[CFG_BADPAR]) |=> bad_par);

  a_r11_badpar_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(ue_evt && cfg[CFG_BADPAR]) |=> !bad_par);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_evt   (ce_evt),
  .ue_evt   (ue_evt),
  .cfg      (cfg),
  .st_wr    (st_wr),
  .st_wdata (st_wdata),
  .status   (status),
  .serr_n   (serr_n),
  .bad_par  (bad_par),
  .rise_w   (rise_w)
);

// File: tb/ecc_err_logger_bench.sv
`timescale 1ns/1ps
module ecc_err_logger_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_evt = 1'b0;
  logic [2:0] ce_row = '0;
  logic       ue_evt = 1'b0;
  logic [2:0] ue_row = '0;
  logic [7:0] cfg = '0;
  logic       st_wr = 1'b0;
  logic [7:0] st_wdata = '0;
  logic [7:0] status;
  logic       serr_n;
  logic       bad_par;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  ecc_err_logger u_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ce_row(ce_row),
    .ue_evt(ue_evt), .ue_row(ue_row), .cfg(cfg), .st_wr(st_wr),
    .st_wdata(st_wdata), .status(status), .serr_n(serr_n), .bad_par(bad_par)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] stat_of(input logic cf, input logic [2:0] cr,
                                         input logic uf, input logic [2:0] ur);
    return {ur, uf, cr, cf};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive for one clock from a falling edge; returns at the next falling edge
  task automatic drive(input logic ce, input logic [2:0] cr, input logic ue,
                       input logic [2:0] ur, input logic wr, input logic [7:0] wd);
    ce_evt = ce; ce_row = cr; ue_evt = ue; ue_row = ur; st_wr = wr; st_wdata = wd;
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0; st_wr = 1'b0; st_wdata = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic clear_all();
    drive(0, 0, 0, 0, 1, 8'hFF);
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h00);
    check("R1 serr_n", serr_n, 1);
    check("R1 bad_par", bad_par, 0);
  endtask

  task automatic t_ce_capture();
    cfg = 8'h01;
    drive(1, 3'd5, 0, 0, 0, 0);
    check("R2 ce flag+row", status, stat_of(1, 3'd5, 0, 0));
    check("R9 strobe low", serr_n, 0);
    idle();
    check("R9 strobe one cycle", serr_n, 1);
    drive(1, 3'd2, 0, 0, 0, 0);
    check("R4 ce row held", status, stat_of(1, 3'd5, 0, 0));
    check("R9 no strobe while set", serr_n, 1);
    drive(0, 0, 0, 0, 1, 8'h01);
    check("R5 ce cleared", status & 8'h11, 8'h00);
    clear_all();
  endtask

  task automatic t_ue_capture();
    cfg = 8'h02;
    drive(0, 0, 1, 3'd6, 0, 0);
    check("R3 ue flag+row", status, stat_of(0, 3'd5, 1, 3'd6));
    check("R9 ue strobe", serr_n, 0);
    drive(0, 0, 1, 3'd1, 0, 0);
    check("R4 ue row held", status[7:4], {3'd6, 1'b1});
    drive(0, 0, 0, 0, 1, 8'h01);
    check("R5 other flag kept", status[7:4], {3'd6, 1'b1});
    drive(0, 0, 0, 0, 1, 8'hEE);
    check("R5 non-flag bits ignored", status[7:4], {3'd6, 1'b1});
    drive(0, 0, 0, 0, 0, 8'h10);
    check("R5 no strobe no clear", status[4], 1);
    drive(0, 0, 0, 0, 1, 8'h10);
    check("R5 ue cleared", status[4], 0);
    clear_all();
  endtask

  task automatic t_set_wins();
    cfg = 8'h01;
    drive(1, 3'd1, 0, 0, 0, 0);
    check("R2 first capture", status[3:0], {3'd1, 1'b1});
    idle();
    drive(1, 3'd7, 0, 0, 1, 8'h01);
    check("R6 set wins, new row", status[3:0], {3'd7, 1'b1});
    check("R6 no strobe", serr_n, 1);
    clear_all();
  endtask

  task automatic t_both();
    cfg = 8'h03;
    drive(1, 3'd3, 1, 3'd4, 0, 0);
    check("R7 both captured", status, stat_of(1, 3'd3, 1, 3'd4));
    check("R7 strobe", serr_n, 0);
    idle();
    check("R9 single strobe", serr_n, 1);
    clear_all();
  endtask

  task automatic t_level();
    cfg = 8'h83;
    drive(0, 0, 1, 3'd2, 0, 0);
    check("R10 low on ue", serr_n, 0);
    idle(); idle();
    check("R10 held low", serr_n, 0);
    drive(1, 3'd0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 8'h10);
    check("R10 still low with ce set", serr_n, 0);
    drive(0, 0, 0, 0, 1, 8'h01);
    check("R10 released after clear", serr_n, 1);
    check("R10 flags clear", status & 8'h11, 8'h00);
    clear_all();
  endtask

  task automatic t_enable();
    cfg = 8'h81;
    drive(0, 0, 1, 3'd3, 0, 0);
    check("R8 ue disabled level", serr_n, 1);
    clear_all();
    cfg = 8'h02;
    drive(1, 3'd4, 0, 0, 0, 0);
    check("R8 ce disabled pulse", serr_n, 1);
    idle();
    check("R8 ce disabled pulse later", serr_n, 1);
    clear_all();
  endtask

  task automatic t_badpar();
    cfg = 8'h04;
    drive(0, 0, 1, 3'd1, 0, 0);
    check("R11 bad_par on", bad_par, 1);
    idle();
    check("R11 bad_par one cycle", bad_par, 0);
    drive(0, 0, 1, 3'd2, 0, 0);
    check("R11 bad_par every event", bad_par, 1);
    drive(1, 3'd2, 0, 0, 0, 0);
    check("R11 not on ce", bad_par, 0);
    clear_all();
    cfg = 8'h00;
    drive(0, 0, 1, 3'd5, 0, 0);
    check("R11 disabled", bad_par, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ce_capture();
    t_ue_capture();
    t_set_wins();
    t_both();
    t_level();
    t_enable();
    t_badpar();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule